// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the eight-bit status register of an I2C controller. The bus engine sends it one-cycle event strobes: start and stop detection, address match results, transmit-empty and receive-full events, and SCL edge samples used for arbitration. It also receives level inputs that give the operating mode and whether a frame is still in progress. The block applies the set and clear rule of each flag and presents the register on a read port.

Software sees seven sticky flags and one plain acknowledge bit. A sticky flag cannot be set by software. It clears only when software writes 0 to it after it has read that flag as 1. Several flags also clear as a side effect of bus activity: an access to the data register, entering master mode, a start condition, or the clearing of the controller's separate interrupt-request flag.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset all eight bits of `rdata` are 0.
- R2: Writing 1 to any of bits 7..1 leaves that bit unchanged. Writing 0 to one of these bits clears it only when a register read saw that bit as 1 after it was last set and after it was last cleared. A read in the same cycle as the write does not count. Once a flag has been cleared by any means, the earlier read no longer counts.
- R3: When a set event and a clear of a flag happen in the same cycle, the flag stays set, and a new read is needed before a write of 0 can clear it.
- R4: Bit 7 (error stop) sets on a stop strobe in I2C slave mode (`is_master`=0, `i2c_fmt`=1) while `in_frame`=1. It also clears when `irq_clr` pulses.
- R5: Bit 6 (normal stop) sets on a stop strobe in I2C slave mode while `in_frame`=0. It also clears when `irq_clr` pulses.
- R6: Bit 5 (continuous transfer) sets on a transmit-empty or receive-full strobe. In I2C slave mode this happens only while bit 4 is 1; in any other mode it always happens. It also clears when `irq_clr` pulses.
- R7: Bit 4 (second address) sets on `addr2_hit` in slave receive mode when `fs_b`=0. It clears on a start strobe or while `is_master`=1.
- R8: Bit 3 (arbitration lost) sets in master transmit mode in two cases: at `scl_rise` when `sda_int`≠`sda_pin`, or at `scl_fall` when `scl_int`=1. It clears on any data register read or write.
- R9: Bit 2 (address match) sets on `addr1_hit` or `gcall_hit` in slave receive mode when `fs_a`=0. It clears on a data register write while transmitting, on a data register read while receiving, or while `is_master`=1.
- R10: Bit 1 (general call) sets on `gcall_hit` in slave receive mode when `fs_a`=0 or `fs_b`=0. It has the same side-effect clears as bit 2.
- R11: Bit 0 (acknowledge) takes `wdata[0]` on every register write. When there is no write, it captures `ack_rx_bit` on `ack_rx_valid` while `is_tx`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master mode |
| is_tx | input | 1 | 1 = transmit direction |
| i2c_fmt | input | 1 | 1 = I2C bus format selected |
| fs_a | input | 1 | Primary format select |
| fs_b | input | 1 | Secondary format select |
| in_frame | input | 1 | Frame transfer still in progress |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| addr1_hit | input | 1 | Own slave address matched |
| addr2_hit | input | 1 | Second slave address matched |
| gcall_hit | input | 1 | General call address matched |
| tdre_set | input | 1 | Transmit buffer became empty |
| rdrf_set | input | 1 | Receive buffer became full |
| scl_rise | input | 1 | SCL rising edge sample strobe |
| scl_fall | input | 1 | SCL falling edge sample strobe |
| sda_int | input | 1 | SDA level the controller drives |
| sda_pin | input | 1 | SDA level seen on the pin |
| scl_int | input | 1 | SCL level the controller drives |
| ack_rx_valid | input | 1 | Acknowledge slot sampled |
| ack_rx_bit | input | 1 | Acknowledge level returned by receiver |
| irq_clr | input | 1 | Interrupt-request flag cleared |
| sr_rd | input | 1 | Read of this register |
| sr_wr | input | 1 | Write of this register |
| wdata | input | 8 | Write data |
| dr_rd | input | 1 | Read of the data register |
| dr_wr | input | 1 | Write of the data register |
| rdata | output | 8 | Register contents |

## Verification
The hardest case to reach is the collision on a flag that was already read as 1: a new set event arriving in the same cycle as the write of 0. The stimulus sets the arbitration flag, reads it, and then fires a mismatched SCL rising edge in the same cycle as the write. It then writes 0 again without reading, to show that the pending clear was cancelled. A second hard case is a clear that has lost its effect: a flag is read, cleared by a data register access, set again, and then written with 0. After the directed cases, a long randomized phase with sparse strobes compares every bit each cycle against a behavioural model.

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_master,
  input  logic       is_tx,
  input  logic       i2c_fmt,
  input  logic       fs_a,
  input  logic       fs_b,
  input  logic       in_frame,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       addr1_hit,
  input  logic       addr2_hit,
  input  logic       gcall_hit,
  input  logic       tdre_set,
  input  logic       rdrf_set,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_int,
  input  logic       sda_pin,
  input  logic       scl_int,
  input  logic       ack_rx_valid,
  input  logic       ack_rx_bit,
  input  logic       irq_clr,
  input  logic       sr_rd,
  input  logic       sr_wr,
  input  logic [7:0] wdata,
  input  logic       dr_rd,
  input  logic       dr_wr,
  output logic [7:0] rdata
);
  localparam int NF = 7;

  logic [NF:1] flag, arm, set_ev, hw_clr;
  logic        ack_q;

  wire slave_i2c = !is_master && i2c_fmt;
  wire slave_rx  = slave_i2c && !is_tx;
  wire dr_acc    = (dr_wr && is_tx) || (dr_rd && !is_tx);

  assign set_ev[7] = ev_stop && slave_i2c && in_frame;
  assign set_ev[6] = ev_stop && slave_i2c && !in_frame;
  assign set_ev[5] = (tdre_set || rdrf_set) && (slave_i2c ? flag[4] : 1'b1);
  assign set_ev[4] = addr2_hit && slave_rx && !fs_b;
  assign set_ev[3] = is_master && is_tx &&
                     ((scl_rise && (sda_int != sda_pin)) || (scl_fall && scl_int));
  assign set_ev[2] = (addr1_hit || gcall_hit) && slave_rx && !fs_a;
  assign set_ev[1] = gcall_hit && slave_rx && (!fs_a || !fs_b);

  assign hw_clr[7] = irq_clr;
  assign hw_clr[6] = irq_clr;
  assign hw_clr[5] = irq_clr;
  assign hw_clr[4] = ev_start || is_master;
  assign hw_clr[3] = dr_wr || dr_rd;
  assign hw_clr[2] = dr_acc || is_master;
  assign hw_clr[1] = dr_acc || is_master;

  for (genvar i = 1; i <= NF; i++) begin : g_flag
    logic wr0, nxt;
    assign wr0 = sr_wr && !wdata[i];
    assign nxt = set_ev[i] || (flag[i] && !(wr0 && arm[i]) && !hw_clr[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        arm[i]  <= 1'b0;
      end else begin
        flag[i] <= nxt;
        arm[i]  <= !set_ev[i] && nxt && ((arm[i] && !wr0) || (sr_rd && flag[i]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ack_q <= 1'b0;
    else if (sr_wr)                  ack_q <= wdata[0];
    else if (ack_rx_valid && is_tx)  ack_q <= ack_rx_bit;
  end

  assign rdata = {flag, ack_q};

  a_r4_estp_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[7]) |-> $past(ev_stop && in_frame && !is_master));
  a_r5_nstp_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[6]) |-> $past(ev_stop && !in_frame && !is_master));
  a_r8_arb_needs_master_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[3]) |-> $past(is_master && is_tx && (scl_rise || scl_fall)));
  a_r9_master_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> (rdata[4] == 1'b0 && rdata[2] == 1'b0 && rdata[1] == 1'b0));
  a_r4_irq_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !ev_stop && !tdre_set && !rdrf_set) |=> rdata[7:5] == 3'b000);
  a_r2_no_clear_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_rd && !irq_clr && !ev_start && !is_master && !dr_rd && !dr_wr && $past(!sr_rd))
      |=> rdata[7:1] == ($past(rdata[7:1]) | rdata[7:1]) || $past(sr_wr));
endmodule

// File: tb/i2c_stat_reg_tb.sv
`timescale 1ns/1ps
module i2c_stat_reg_tb;
  logic clk = 0, rst_n = 0;
  logic is_master, is_tx, i2c_fmt, fs_a, fs_b, in_frame;
  logic ev_start, ev_stop, addr1_hit, addr2_hit, gcall_hit, tdre_set, rdrf_set;
  logic scl_rise, scl_fall, sda_int, sda_pin, scl_int, ack_rx_valid, ack_rx_bit;
  logic irq_clr, sr_rd, sr_wr, dr_rd, dr_wr;
  logic [7:0] wdata, rdata;
  int tests = 0, fails = 0;
  bit done = 0;
  bit mf[8];
  bit ma[8];

  always #2.5 clk = ~clk;

  i2c_stat_reg u_dut (.*);

  // reference model: applied at each rising edge from the inputs held across it
  always @(posedge clk) begin
    bit s[8];
    bit c[8];
    bit slv, srx, acc;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin mf[k] = 0; ma[k] = 0; end
    end else begin
      slv = !is_master && i2c_fmt;
      srx = slv && !is_tx;
      acc = (dr_wr && is_tx) || (dr_rd && !is_tx);
      for (int k = 0; k < 8; k++) begin s[k] = 0; c[k] = 0; end
      if (ev_stop && slv) begin
        if (in_frame) s[7] = 1; else s[6] = 1;
      end
      if (tdre_set || rdrf_set) s[5] = slv ? mf[4] : 1;
      if (addr2_hit && srx && !fs_b) s[4] = 1;
      if (is_master && is_tx) begin
        if (scl_rise && sda_int != sda_pin) s[3] = 1;
        if (scl_fall && scl_int) s[3] = 1;
      end
      if ((addr1_hit || gcall_hit) && srx && !fs_a) s[2] = 1;
      if (gcall_hit && srx && (!fs_a || !fs_b)) s[1] = 1;
      if (irq_clr) begin c[7] = 1; c[6] = 1; c[5] = 1; end
      if (ev_start || is_master) c[4] = 1;
      if (dr_rd || dr_wr) c[3] = 1;
      if (acc || is_master) begin c[2] = 1; c[1] = 1; end
      for (int k = 1; k < 8; k++) begin
        bit wz, was, wasarm;
        wz = sr_wr && !wdata[k];
        was = mf[k]; wasarm = ma[k];
        if (s[k]) begin mf[k] = 1; ma[k] = 0; end
        else begin
          if (c[k] || (wz && wasarm)) mf[k] = 0;
          if (!mf[k]) ma[k] = 0;
          else ma[k] = (wasarm && !wz) || (sr_rd && was);
        end
      end
      if (sr_wr) mf[0] = wdata[0];
      else if (ack_rx_valid && is_tx) mf[0] = ack_rx_bit;
    end
  end

  function automatic string tag(int b);
    case (b)
      7: return "R4"; 6: return "R5"; 5: return "R6"; 4: return "R7";
      3: return "R8"; 2: return "R9"; 1: return "R10"; default: return "R11";
    endcase
  endfunction

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) if (rst_n && !done) begin
    for (int b = 0; b < 8; b++) begin
      tests++;
      if (rdata[b] !== mf[b]) begin
        fails++;
        $display("FAIL %s bit%0d actual=%b expected=%b t=%0t", tag(b), b, rdata[b], mf[b], $time);
      end
    end
  end

  task automatic idle();
    ev_start = 0; ev_stop = 0; addr1_hit = 0; addr2_hit = 0; gcall_hit = 0;
    tdre_set = 0; rdrf_set = 0; scl_rise = 0; scl_fall = 0; ack_rx_valid = 0;
    irq_clr = 0; sr_rd = 0; sr_wr = 0; dr_rd = 0; dr_wr = 0; wdata = 8'hFF;
  endtask
  task automatic tick(); @(negedge clk); idle(); endtask
  task automatic mode(bit m, bit t); is_master = m; is_tx = t; endtask
  task automatic rd(); sr_rd = 1; tick(); endtask
  task automatic wr(logic [7:0] d); sr_wr = 1; wdata = d; tick(); endtask
  task automatic expect_bit(string r, int b, bit e);
    tests++;
    if (rdata[b] !== e) begin
      fails++;
      $display("FAIL %s directed bit%0d actual=%b expected=%b", r, b, rdata[b], e);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(); mode(0, 0); i2c_fmt = 1; fs_a = 0; fs_b = 0; in_frame = 0;
    sda_int = 0; sda_pin = 0; scl_int = 0; ack_rx_bit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++; if (rdata !== 8'h00) begin fails++; $display("FAIL R1 actual=%h expected=00", rdata); end

    // R9 address match, R2 write 0 without read keeps it
    addr1_hit = 1; tick(); tick();
    expect_bit("R9", 2, 1);
    wr(8'h00); tick(); expect_bit("R2", 2, 1);
    wr(8'hFF); tick(); expect_bit("R2", 2, 1); expect_bit("R11", 0, 1);
    rd(); wr(8'h00); tick(); expect_bit("R2", 2, 0);

    // R10 general call only when fs_a=1 fs_b=0
    fs_a = 1; gcall_hit = 1; tick(); tick();
    expect_bit("R10", 1, 1); expect_bit("R9", 2, 0);
    fs_a = 0;
    // R2 arm dropped by a side-effect clear (data read while receiving)
    rd(); dr_rd = 1; tick(); gcall_hit = 1; tick(); wr(8'h00); tick();
    expect_bit("R2", 1, 1);
    rd(); wr(8'h00); tick();

    // R7/R6 second address and continuous flag
    addr2_hit = 1; tick(); tdre_set = 1; tick(); tick();
    expect_bit("R7", 4, 1); expect_bit("R6", 5, 1);
    ev_start = 1; tick(); irq_clr = 1; tick(); rdrf_set = 1; tick(); tick();
    expect_bit("R7", 4, 0); expect_bit("R6", 5, 0);

    // R4/R5 stop flags and irq clear
    in_frame = 1; ev_stop = 1; tick(); in_frame = 0; ev_stop = 1; tick(); tick();
    expect_bit("R4", 7, 1); expect_bit("R5", 6, 1);
    irq_clr = 1; tick(); tick();
    expect_bit("R4", 7, 0); expect_bit("R5", 6, 0);

    // R8 arbitration in master transmit; R6 unconditional in master mode
    mode(1, 1); tdre_set = 1; sda_int = 1; sda_pin = 0; scl_rise = 1; tick(); tick();
    expect_bit("R8", 3, 1); expect_bit("R6", 5, 1);
    dr_wr = 1; tick(); scl_int = 1; scl_fall = 1; tick(); tick();
    expect_bit("R8", 3, 1); scl_int = 0;
    // R3 set and write 0 collide after a read
    rd(); sr_wr = 1; wdata = 8'h00; scl_rise = 1; tick(); tick();
    expect_bit("R3", 3, 1);
    wr(8'h00); tick(); expect_bit("R3", 3, 1);
    rd(); wr(8'h00); tick(); expect_bit("R8", 3, 0);
    sda_int = 0;

    // R11 acknowledge capture while transmitting
    ack_rx_valid = 1; ack_rx_bit = 1; tick(); tick(); expect_bit("R11", 0, 1);
    ack_rx_valid = 1; ack_rx_bit = 0; tick(); tick(); expect_bit("R11", 0, 0);
    irq_clr = 1; tick();

    // R9/R10/R7 master entry clears
    mode(0, 0); addr1_hit = 1; gcall_hit = 1; addr2_hit = 1; tick();
    mode(1, 0); tick(); tick();
    expect_bit("R9", 2, 0); expect_bit("R10", 1, 0); expect_bit("R7", 4, 0);

    // randomized phase, model compared on every clock
    for (int n = 0; n < 4000; n++) begin
      is_master = ($urandom % 8) == 0; is_tx = $urandom; i2c_fmt = ($urandom % 4) != 0;
      fs_a = ($urandom % 3) == 0; fs_b = ($urandom % 3) == 0; in_frame = $urandom;
      ev_start = ($urandom % 16) == 0; ev_stop = ($urandom % 10) == 0;
      addr1_hit = ($urandom % 6) == 0; addr2_hit = ($urandom % 6) == 0;
      gcall_hit = ($urandom % 8) == 0; tdre_set = ($urandom % 6) == 0;
      rdrf_set = ($urandom % 8) == 0; scl_rise = ($urandom % 4) == 0;
      scl_fall = ($urandom % 4) == 0; sda_int = $urandom; sda_pin = $urandom;
      scl_int = $urandom; ack_rx_valid = ($urandom % 5) == 0; ack_rx_bit = $urandom;
      irq_clr = ($urandom % 12) == 0; sr_rd = ($urandom % 3) == 0;
      sr_wr = ($urandom % 4) == 0; wdata = $urandom;
      dr_rd = ($urandom % 10) == 0; dr_wr = ($urandom % 10) == 0;
      @(negedge clk);
    end
    idle(); tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule